// File: doc/BRIEF.md
# Windowed Frame-RAM Address Generator

This block produces the byte addresses for a one-bit-per-pixel panel frame memory. A processor-side byte stream (a command code followed by its data bytes) programs a rectangular window, a scan direction for rows and the starting X/Y position. Each incoming pixel-data byte strobe then yields one memory write at the current position, after which the position moves on. X is kept in pixels and moves 8 pixels per byte. Rows can be walked upward or downward, so an image can be stored bottom-to-top inside any window.

The block also has a fill operation. A fill command plus one pattern byte makes the block write that pattern into every byte of the window, one byte per clock, while a busy flag is high. The memory array itself sits outside the block and is driven by the address, write enable and pattern outputs.

Top module: `frame_addr_gen`

## Requirements
- R1: After reset the address is 0, the write enable and busy flag are low, the window spans the whole 800x480 frame (X 0..799, Y 0..479) and rows advance upward (increasing Y).
- R2: Command code 0x11 followed by one data byte sets the row direction from bit 1 of that byte (1 = Y increments, 0 = Y decrements); all other bits of that byte have no effect.
- R3: Command 0x44 (X window) and 0x45 (Y window) each take four data bytes in this order: start low, start high, end low, end high.
- R4: Command 0x4E (X position) and 0x4F (Y position) each take two data bytes, low then high; the position changes only once the high byte arrives.
- R5: The address output always equals Y x 100 + X / 8, where the three low bits of X are dropped.
- R6: In a cycle with the pixel strobe high and no fill running, the write enable is high in that same cycle with the current address, and X then moves forward by 8 pixels; with no strobe and no fill, the write enable is low.
- R7: When X + 8 would exceed the X window end, X returns to the X window start and Y steps one row in the programmed direction.
- R8: On that row step, when Y is already at (or past) the Y window end in the direction of travel, Y returns to the Y window start instead.
- R9: Command 0x46 or 0x47 followed by a pattern byte raises the busy flag from the next cycle; the block then writes every window byte exactly once, one per cycle, starting at the window start, presents the pattern on the fill-pattern output, and drops busy after the last byte with the position back at the window start.
- R10: While the busy flag is high, command and data bytes and the pixel strobe are ignored.
- R11: Data bytes beyond the count a command takes, and data bytes following an unknown command code, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A register-port byte is present this cycle |
| cmd_is_data | input | 1 | 0: the byte is a command code, 1: a data byte |
| cmd_byte | input | 8 | Command code or data byte |
| pix_stb | input | 1 | One pixel-data byte is written this cycle |
| addr | output | 16 | Current frame-memory byte address |
| wr_en | output | 1 | Write the memory at addr this cycle |
| fill_busy | output | 1 | Window fill in progress |
| fill_pat | output | 8 | Pattern byte written during a fill |

## Verification
On every cycle the assertions check that the write enable follows the strobe and the busy flag, that the address moves up by exactly one byte whenever a write happens inside a row, and that the window stays frozen for as long as a fill runs. Row wrapping in both directions, the wrap back to the window top, the exact set and order of addresses a fill produces, the busy length and the rejection of port traffic during a fill can only be shown by the bench's scenarios, which predict each write address from a model of the window and compare them in order.

// File: rtl/frame_addr_pkg.sv
package frame_addr_pkg;

    localparam int POS_W = 16;

    localparam logic [7:0] OP_ENTRY  = 8'h11;
    localparam logic [7:0] OP_XWIN   = 8'h44;
    localparam logic [7:0] OP_YWIN   = 8'h45;
    localparam logic [7:0] OP_XPOS   = 8'h4E;
    localparam logic [7:0] OP_YPOS   = 8'h4F;
    localparam logic [7:0] OP_FILL_A = 8'h46;
    localparam logic [7:0] OP_FILL_B = 8'h47;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ENTRY,
        SEL_XWIN,
        SEL_YWIN,
        SEL_XPOS,
        SEL_YPOS,
        SEL_FILL
    } sel_e;

    typedef struct packed {
        logic             y_inc;
        logic [POS_W-1:0] x_start;
        logic [POS_W-1:0] x_end;
        logic [POS_W-1:0] y_start;
        logic [POS_W-1:0] y_end;
    } win_cfg_t;

    typedef struct packed {
        logic             ld_x;
        logic             ld_y;
        logic [POS_W-1:0] value;
    } pos_load_t;

    function automatic sel_e decode_op(input logic [7:0] op);
        case (op)
            OP_ENTRY:             return SEL_ENTRY;
            OP_XWIN:              return SEL_XWIN;
            OP_YWIN:              return SEL_YWIN;
            OP_XPOS:              return SEL_XPOS;
            OP_YPOS:              return SEL_YPOS;
            OP_FILL_A, OP_FILL_B: return SEL_FILL;
            default:              return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/frame_addr_decode.sv
module frame_addr_decode
    import frame_addr_pkg::*;
#(
    parameter int COLS = 800,
    parameter int ROWS = 480
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_is_data,
    input  logic [7:0] in_byte,
    output win_cfg_t   cfg,
    output pos_load_t  ld,
    output logic       fill_go,
    output logic [7:0] fill_pat
);

    localparam logic [2:0] IDX_DONE = 3'd4;

    sel_e       sel_q;
    logic [2:0] idx_q;
    logic [7:0] lo_q;
    logic       data_ok;

    assign data_ok = in_valid && in_is_data && (idx_q != IDX_DONE);

    // Position loads and fill start act in the cycle of their final byte.
    always_comb begin
        ld       = '0;
        ld.value = {in_byte, lo_q};
        fill_go  = 1'b0;
        if (data_ok) begin
            case (sel_q)
                SEL_XPOS: ld.ld_x   = (idx_q == 3'd1);
                SEL_YPOS: ld.ld_y   = (idx_q == 3'd1);
                SEL_FILL: fill_go   = (idx_q == 3'd0);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q       <= SEL_NONE;
            idx_q       <= '0;
            lo_q        <= '0;
            fill_pat    <= '0;
            cfg.y_inc   <= 1'b1;
            cfg.x_start <= '0;
            cfg.x_end   <= POS_W'(COLS - 1);
            cfg.y_start <= '0;
            cfg.y_end   <= POS_W'(ROWS - 1);
        end else if (in_valid && !in_is_data) begin
            sel_q <= decode_op(in_byte);
            idx_q <= '0;
        end else if (data_ok) begin
            idx_q <= idx_q + 3'd1;
            case (sel_q)
                SEL_ENTRY: if (idx_q == 3'd0) cfg.y_inc <= in_byte[1];
                SEL_XWIN: begin
                    case (idx_q)
                        3'd0:    cfg.x_start[7:0]  <= in_byte;
                        3'd1:    cfg.x_start[15:8] <= in_byte;
                        3'd2:    cfg.x_end[7:0]    <= in_byte;
                        default: cfg.x_end[15:8]   <= in_byte;
                    endcase
                end
                SEL_YWIN: begin
                    case (idx_q)
                        3'd0:    cfg.y_start[7:0]  <= in_byte;
                        3'd1:    cfg.y_start[15:8] <= in_byte;
                        3'd2:    cfg.y_end[7:0]    <= in_byte;
                        default: cfg.y_end[15:8]   <= in_byte;
                    endcase
                end
                SEL_XPOS, SEL_YPOS: if (idx_q == 3'd0) lo_q <= in_byte;
                SEL_FILL:  if (idx_q == 3'd0) fill_pat <= in_byte;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/frame_addr_walk.sv
module frame_addr_walk
    import frame_addr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  win_cfg_t         cfg,
    input  pos_load_t        ld,
    input  logic             fill_go,
    input  logic             pix_stb,
    output logic [POS_W-1:0] x_q,
    output logic [POS_W-1:0] y_q,
    output logic             busy_q,
    output logic             step
);

    logic [POS_W:0]   x_plus;
    logic             x_wrap;
    logic             y_wrap;
    logic [POS_W-1:0] x_next;
    logic [POS_W-1:0] y_next;

    assign step   = busy_q || pix_stb;
    assign x_plus = {1'b0, x_q} + (POS_W+1)'(8);
    assign x_wrap = x_plus > {1'b0, cfg.x_end};
    assign y_wrap = cfg.y_inc ? (y_q >= cfg.y_end) : (y_q <= cfg.y_end);

    always_comb begin
        x_next = x_wrap ? cfg.x_start : x_plus[POS_W-1:0];
        y_next = y_q;
        if (x_wrap) begin
            if (y_wrap)         y_next = cfg.y_start;
            else if (cfg.y_inc) y_next = y_q + POS_W'(1);
            else                y_next = y_q - POS_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            busy_q <= 1'b0;
        end else if (fill_go) begin
            x_q    <= cfg.x_start;
            y_q    <= cfg.y_start;
            busy_q <= 1'b1;
        end else begin
            if (step) begin
                x_q <= x_next;
                y_q <= y_next;
                if (busy_q && x_wrap && y_wrap) busy_q <= 1'b0;
            end
            if (ld.ld_x) x_q <= ld.value;
            if (ld.ld_y) y_q <= ld.value;
        end
    end

endmodule

// File: rtl/frame_addr_map.sv
module frame_addr_map
    import frame_addr_pkg::*;
#(
    parameter int ROW_BYTES = 100,
    parameter int AW        = 16
) (
    input  logic [POS_W-1:0] x,
    input  logic [POS_W-1:0] y,
    output logic [AW-1:0]    addr
);

    assign addr = AW'(32'(y) * ROW_BYTES + 32'(x >> 3));

endmodule

// File: rtl/frame_addr_gen.sv
module frame_addr_gen
    import frame_addr_pkg::*;
#(
    parameter int COLS = 800,
    parameter int ROWS = 480,
    localparam int ROW_BYTES = COLS / 8,
    localparam int AW        = $clog2(ROW_BYTES * ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic          cmd_is_data,
    input  logic [7:0]    cmd_byte,
    input  logic          pix_stb,
    output logic [AW-1:0] addr,
    output logic          wr_en,
    output logic          fill_busy,
    output logic [7:0]    fill_pat
);

    win_cfg_t         cfg_q;
    pos_load_t        pos_ld;
    logic             fill_go;
    logic             port_open;
    logic [POS_W-1:0] x_q;
    logic [POS_W-1:0] y_q;

    assign port_open = cmd_valid && !fill_busy;

    frame_addr_decode #(.COLS(COLS), .ROWS(ROWS)) u_decode (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (port_open),
        .in_is_data (cmd_is_data),
        .in_byte    (cmd_byte),
        .cfg        (cfg_q),
        .ld         (pos_ld),
        .fill_go    (fill_go),
        .fill_pat   (fill_pat)
    );

    frame_addr_walk u_walk (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg_q),
        .ld      (pos_ld),
        .fill_go (fill_go),
        .pix_stb (pix_stb),
        .x_q     (x_q),
        .y_q     (y_q),
        .busy_q  (fill_busy),
        .step    (wr_en)
    );

    frame_addr_map #(.ROW_BYTES(ROW_BYTES), .AW(AW)) u_map (
        .x    (x_q),
        .y    (y_q),
        .addr (addr)
    );

endmodule

// File: rtl/frame_addr_gen_chk.sv
module frame_addr_gen_chk
    import frame_addr_pkg::*;
#(
    parameter int AW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             pix_stb,
    input logic             wr_en,
    input logic             fill_busy,
    input logic [AW-1:0]    addr,
    input logic [POS_W-1:0] x_pos,
    input win_cfg_t         cfg
);

    logic in_row;
    assign in_row = ((POS_W+1)'(x_pos) + (POS_W+1)'(8)) <= (POS_W+1)'(cfg.x_end);

    // R6: a strobe outside a fill writes in the same cycle
    p_pix_write_r6: assert property (@(posedge clk) disable iff (rst)
        (pix_stb && !fill_busy) |-> wr_en);

    // R6: no strobe and no fill means no write
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!pix_stb && !fill_busy) |-> !wr_en);

    // R9: a running fill writes every cycle
    p_fill_writes_r9: assert property (@(posedge clk) disable iff (rst)
        fill_busy |-> wr_en);

    // R5, R6: a write inside a row moves the address by one byte
    p_row_advance_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cmd_valid && in_row) |=> (addr == $past(addr) + AW'(1)));

    // R10: the window cannot change while a fill runs
    p_window_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        fill_busy |=> ($stable(cfg.x_start) && $stable(cfg.x_end) &&
                       $stable(cfg.y_start) && $stable(cfg.y_end) &&
                       $stable(cfg.y_inc)));

endmodule

bind frame_addr_gen frame_addr_gen_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .pix_stb   (pix_stb),
    .wr_en     (wr_en),
    .fill_busy (fill_busy),
    .addr      (addr),
    .x_pos     (x_q),
    .cfg       (cfg_q)
);

// File: tb/frame_addr_gen_test.sv
`timescale 1ns/100ps
module frame_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_is_data = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        pix_stb = 1'b0;
    logic [15:0] addr;
    logic        wr_en;
    logic        fill_busy;
    logic [7:0]  fill_pat;

    always #2 clk = ~clk;

    frame_addr_gen uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_is_data(cmd_is_data),
        .cmd_byte(cmd_byte), .pix_stb(pix_stb), .addr(addr), .wr_en(wr_en),
        .fill_busy(fill_busy), .fill_pat(fill_pat)
    );

    typedef struct {
        int       a;
        bit       is_fill;
        int       pat;
        string    tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    int busy_cnt = 0;
    bit done = 0;

    // window model built from the requirements
    int m_x = 0, m_y = 0, m_xs = 0, m_xe = 799, m_ys = 0, m_ye = 479;
    bit m_yinc = 1;

    function automatic int m_addr();
        return m_y * 100 + m_x / 8;
    endfunction

    task automatic m_step();
        if (m_x + 8 > m_xe) begin
            m_x = m_xs;
            if (m_yinc ? (m_y >= m_ye) : (m_y <= m_ye)) m_y = m_ys;
            else if (m_yinc) m_y = m_y + 1;
            else m_y = m_y - 1;
        end else begin
            m_x = m_x + 8;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: compare every write against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && fill_busy) busy_cnt++;
        if (!rst && wr_en) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R10: unexpected write at addr actual %0d expected none", addr);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " addr"}, int'(addr), e.a);
                if (e.is_fill) chk({e.tag, " pattern"}, int'(fill_pat), e.pat);
            end
        end
    end

    task automatic send(input bit d, input logic [7:0] b);
        cmd_valid = 1'b1; cmd_is_data = d; cmd_byte = b;
        @(posedge clk); #0.5;
        cmd_valid = 1'b0; cmd_is_data = 1'b0;
    endtask

    task automatic set_mode(input logic [7:0] b);
        send(0, 8'h11); send(1, b);
        m_yinc = b[1];
    endtask

    task automatic set_win(input logic [7:0] op, input int s, input int e);
        send(0, op);
        send(1, s[7:0]); send(1, s[15:8]); send(1, e[7:0]); send(1, e[15:8]);
        if (op == 8'h44) begin m_xs = s; m_xe = e; end
        else begin m_ys = s; m_ye = e; end
    endtask

    task automatic set_pos(input logic [7:0] op, input int v);
        send(0, op); send(1, v[7:0]); send(1, v[15:8]);
        if (op == 8'h4E) m_x = v; else m_y = v;
    endtask

    task automatic pix(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            pix_stb = 1'b1;
            exp_q.push_back('{m_addr(), 1'b0, 0, tag});
            m_step();
            @(posedge clk); #0.5;
        end
        pix_stb = 1'b0;
    endtask

    // fill with port traffic injected while busy (R10)
    task automatic fill(input logic [7:0] op, input logic [7:0] pat, input int n_bytes);
        m_x = m_xs; m_y = m_ys;
        for (int i = 0; i < n_bytes; i++) begin
            exp_q.push_back('{m_addr(), 1'b1, int'(pat), "R9 fill"});
            m_step();
        end
        busy_cnt = 0;
        send(0, op);
        send(1, pat);
        #0.5;
        chk("R9 busy rises", int'(fill_busy), 1);
        pix_stb = 1'b1;
        send(0, 8'h4E); send(1, 8'h00); send(1, 8'h00);
        pix_stb = 1'b0;
        while (fill_busy) begin @(posedge clk); #0.5; end
        #0.5;
        chk("R9 busy length", busy_cnt, n_bytes);
        chk("R9 position back at window start", int'(addr), m_ys * 100 + m_xs / 8);
        chk("R9 queue drained", exp_q.size(), 0);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst = 1'b0;
        #0.5;
        chk("R1 reset addr", int'(addr), 0);
        chk("R1 reset wr_en", int'(wr_en), 0);
        chk("R1 reset busy", int'(fill_busy), 0);
        @(posedge clk); #0.5;

        // R1 defaults, R6 sequential writes
        pix(3, "R6 default window");

        // R4: low byte alone does not move, high byte does; R5 mapping
        send(0, 8'h4E); send(1, 8'h10);
        #0.5 chk("R4 low byte only", int'(addr), 3);
        send(1, 8'h00); m_x = 16;
        set_pos(8'h4F, 2);
        #0.5 chk("R5 addr from x=16 y=2", int'(addr), 202);

        // R1 full-frame wrap, R8 return to first row
        set_pos(8'h4E, 792); set_pos(8'h4F, 479);
        #0.5 chk("R5 last byte address", int'(addr), 47999);
        pix(2, "R8 default frame wrap");

        // R3, R7, R8 increasing rows in a small window
        set_mode(8'h03);
        set_win(8'h44, 16, 39); set_win(8'h45, 10, 11);
        set_pos(8'h4E, 16); set_pos(8'h4F, 10);
        pix(7, "R7 row step up");

        // R2 other bits ignored, R7/R8 decreasing rows
        set_mode(8'hFD);
        set_win(8'h44, 0, 15); set_win(8'h45, 20, 18);
        set_pos(8'h4E, 0); set_pos(8'h4F, 20);
        pix(7, "R2 R8 row step down");

        // R9, R10 fill upward window
        set_mode(8'h03);
        set_win(8'h44, 8, 23); set_win(8'h45, 5, 6);
        fill(8'h46, 8'hA5, 4);
        pix(2, "R10 state kept after fill");

        // R9 second fill code, downward window
        set_mode(8'h01);
        set_win(8'h44, 0, 15); set_win(8'h45, 20, 18);
        fill(8'h47, 8'h3C, 6);

        // R11: surplus bytes and unknown codes ignored
        set_pos(8'h4E, 8);
        send(0, 8'h4F); send(1, 8'd19); send(1, 8'd0); m_y = 19;
        send(1, 8'd55);
        #0.5 chk("R11 surplus byte", int'(addr), 1901);
        send(0, 8'h99); send(1, 8'h07); send(1, 8'h00);
        #0.5 chk("R11 unknown code", int'(addr), 1901);
        pix(2, "R11 window intact");

        repeat (3) @(posedge clk);
        #0.5 chk("R6 no stray writes", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule